// File: doc/BRIEF.md
# Split-Bus Pipelined Memory Responder

This block is the slave end of a processor-side memory bus. It holds a small array of 64-bit doublewords and answers requests that arrive on a 32-bit address bus. Write data comes in on its own 64-bit bus, and read data goes out on a separate 64-bit bus. A request is either a single word or a cache line. A line is eight 32-bit words, carried as four 64-bit beats that run in ascending order from the line-aligned doubleword.

The block acknowledges a request in the same cycle the request is raised, as long as it can take it. A write delivers its first beat in that acknowledge cycle. A read returns its first beat one cycle later. At most one read and one write can be in flight at a time. A second request of the same direction is held off by keeping the acknowledge low, and the master keeps the request raised until it is taken. A read and a write of opposite directions can run side by side, so a read beat and a write beat may fall in the same cycle. Each read beat carries a 3-bit tag that gives the word position inside the line.

Top module: `splitBusResponder`

## Requirements
- R1: After reset, with no request raised, `addrAck`, `rdDataAck`, `wrDataAck` and `busy` are low, `rdData` and `rdWordAddr` are zero, and every doubleword of the array reads back as zero.
- R2: `addrAck` is high only while `reqValid` is high. It is raised in the same cycle as the request when a read arrives and no read beats are pending, or when a write arrives and no write beats are pending.
- R3: The doubleword index is taken from `reqAddr[6:3]`. Bits 31:7 and 1:0 are ignored. A single-word write stores byte i of `wrData` (bits 8i+7..8i) only where `reqByteEn[i]` is 1. It raises `wrDataAck` in its acknowledge cycle only.
- R4: A line write (`reqLine`=1) takes four beats: one in the acknowledge cycle and one in each of the next three cycles. Beat k is written whole, with the byte enables ignored, to doubleword (index with its two low bits cleared)+k. `wrDataAck` is high in exactly those four cycles.
- R5: A single-word read returns one beat in the cycle after its acknowledge. That beat carries the addressed doubleword on `rdData`, `rdWordAddr` = `reqAddr[4:2]`, and `rdDataAck` high.
- R6: A line read returns four beats in the four cycles after its acknowledge. Beat k carries doubleword base+k and `rdWordAddr` = 2k (the sequence 0, 2, 4, 6), with `rdDataAck` high on each beat.
- R7: While write beats are still pending, a further write request is not acknowledged. It is acknowledged in the first cycle after the last beat, and its data is then stored.
- R8: While read beats are still pending, a further read request is not acknowledged. It is acknowledged in the cycle after the last beat.
- R9: A read can be acknowledged during a line write's beats, and a write can be acknowledged during a read's beats. The read and write beats then occur in the same cycles without disturbing each other.
- R10: `busy` is high from the cycle after an acknowledge through the last beat of every transfer that has a beat after its acknowledge cycle. Otherwise it is low.
- R11: In a cycle with no read beat, `rdData` and `rdWordAddr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request raised |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqLine | input | 1 | 1 = eight-word line, 0 = single word |
| reqAddr | input | 32 | Byte address |
| reqByteEn | input | 8 | Byte enables for single-word writes |
| wrData | input | 64 | Write data beat |
| addrAck | output | 1 | Request accepted this cycle |
| rdData | output | 64 | Read data beat |
| rdWordAddr | output | 3 | Word position of the current read beat |
| rdDataAck | output | 1 | Read beat valid |
| wrDataAck | output | 1 | Write beat taken |
| busy | output | 1 | Accepted transfer still has beats to run |

## Verification
Several rules are checked by assertions on every cycle. An acknowledge never appears without a request. A second acknowledge of the same direction never follows right behind a line write or a read. A write beat always accompanies a write acknowledge, and a read beat always follows a read acknowledge. Tags rise by two across consecutive beats, and the read bus is zero when idle. The stored values and the byte-lane masking can only be shown by the bench's scenarios. The same holds for line alignment, the exact cycle in which a held-off request is finally taken, and overlapping transfers that leave each other's data intact. The bench covers these with a full sweep of the byte enables and of every line and doubleword.

// File: rtl/sbrPkg.sv
package sbrPkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int BE_W = DATA_W / 8;
  localparam int DEPTH = 16;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int BEATS = 4;
  localparam int CNT_W = $clog2(BEATS);
  localparam int TAG_W = 3;
  localparam int BYTE_SHIFT = $clog2(BE_W);
  localparam int WORDS_PER_BEAT = BE_W / 4;

  typedef struct packed {
    logic memWrite;
    logic [IDX_W-1:0] wrIdx;
    logic [BE_W-1:0] wrMask;
    logic rdValid;
    logic [IDX_W-1:0] rdIdx;
  } strobes_t;
endpackage

// File: rtl/sbrControl.sv
module sbrControl
  import sbrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqRead,
  input  logic reqLine,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0] reqByteEn,
  output strobes_t strobes,
  output logic addrAck,
  output logic rdDataAck,
  output logic wrDataAck,
  output logic busy,
  output logic [TAG_W-1:0] rdWordAddr
);
  localparam int LAST = BEATS - 1;
  localparam logic [TAG_W-1:0] TAG_STEP = TAG_W'(WORDS_PER_BEAT);
  localparam logic [IDX_W-1:0] LINE_MASK = ~IDX_W'(BEATS - 1);

  logic rdActive, wrActive;
  logic [IDX_W-1:0] rdIdxQ, wrIdxQ;
  logic [CNT_W-1:0] rdLeft, wrLeft;
  logic [TAG_W-1:0] rdTagQ;
  logic [IDX_W-1:0] reqIdx, lineBase;
  logic rdAccept, wrAccept;
  logic unusedAddrBits;

  assign reqIdx = reqAddr[BYTE_SHIFT +: IDX_W];
  assign lineBase = reqIdx & LINE_MASK;
  assign unusedAddrBits = ^{reqAddr[ADDR_W-1:BYTE_SHIFT+IDX_W], reqAddr[1:0]};

  assign rdAccept = reqValid && reqRead && !rdActive;
  assign wrAccept = reqValid && !reqRead && !wrActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdActive <= 1'b0;
      rdIdxQ <= '0;
      rdLeft <= '0;
      rdTagQ <= '0;
    end else if (rdAccept) begin
      rdActive <= 1'b1;
      rdIdxQ <= reqLine ? lineBase : reqIdx;
      rdLeft <= reqLine ? CNT_W'(LAST) : '0;
      rdTagQ <= reqLine ? '0 : reqAddr[2 +: TAG_W];
    end else if (rdActive) begin
      if (rdLeft == '0) begin
        rdActive <= 1'b0;
      end else begin
        rdIdxQ <= rdIdxQ + 1'b1;
        rdLeft <= rdLeft - 1'b1;
        rdTagQ <= rdTagQ + TAG_STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActive <= 1'b0;
      wrIdxQ <= '0;
      wrLeft <= '0;
    end else if (wrAccept && reqLine) begin
      wrActive <= 1'b1;
      wrIdxQ <= lineBase + 1'b1;
      wrLeft <= CNT_W'(LAST - 1);
    end else if (wrActive) begin
      if (wrLeft == '0) begin
        wrActive <= 1'b0;
      end else begin
        wrIdxQ <= wrIdxQ + 1'b1;
        wrLeft <= wrLeft - 1'b1;
      end
    end
  end

  always_comb begin
    strobes.memWrite = wrAccept || wrActive;
    strobes.wrIdx = wrActive ? wrIdxQ : (reqLine ? lineBase : reqIdx);
    strobes.wrMask = (wrActive || reqLine) ? '1 : reqByteEn;
    strobes.rdValid = rdActive;
    strobes.rdIdx = rdIdxQ;
  end

  assign addrAck = rdAccept || wrAccept;
  assign rdDataAck = rdActive;
  assign wrDataAck = wrAccept || wrActive;
  assign busy = rdActive || wrActive;
  assign rdWordAddr = rdActive ? rdTagQ : '0;
endmodule

// File: rtl/sbrDatapath.sv
module sbrDatapath
  import sbrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  strobes_t strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  for (genvar b = 0; b < BE_W; b++) begin : gLane
    logic [7:0] laneMem [DEPTH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
      end else if (strobes.memWrite && strobes.wrMask[b]) begin
        laneMem[strobes.wrIdx] <= wrData[b*8 +: 8];
      end
    end

    assign rdData[b*8 +: 8] = strobes.rdValid ? laneMem[strobes.rdIdx] : 8'h00;
  end
endmodule

// File: rtl/splitBusResponder.sv
module splitBusResponder
  import sbrPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqRead,
  input  logic reqLine,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0] reqByteEn,
  input  logic [DATA_W-1:0] wrData,
  output logic addrAck,
  output logic [DATA_W-1:0] rdData,
  output logic [TAG_W-1:0] rdWordAddr,
  output logic rdDataAck,
  output logic wrDataAck,
  output logic busy
);
  strobes_t strobes;

  sbrControl i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqLine(reqLine), .reqAddr(reqAddr), .reqByteEn(reqByteEn),
    .strobes(strobes), .addrAck(addrAck), .rdDataAck(rdDataAck),
    .wrDataAck(wrDataAck), .busy(busy), .rdWordAddr(rdWordAddr)
  );

  sbrDatapath i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/sbrChecker.sv
module sbrChecker
  import sbrPkg::*;
(
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqRead,
  input logic reqLine,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [BE_W-1:0] reqByteEn,
  input logic [DATA_W-1:0] wrData,
  input logic addrAck,
  input logic [DATA_W-1:0] rdData,
  input logic [TAG_W-1:0] rdWordAddr,
  input logic rdDataAck,
  input logic wrDataAck,
  input logic busy
);
  logic unusedChk;
  assign unusedChk = ^{reqAddr, reqByteEn, wrData};

  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |-> reqValid);

  a_r3_write_beat_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && !reqRead) |-> wrDataAck);

  a_r4_line_second_beat: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && !reqRead && reqLine) |=> wrDataAck);

  a_r5_read_beat_follows: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && reqRead) |=> (rdDataAck && busy));

  a_r6_tag_steps: assert property (@(posedge clk) disable iff (!rstN)
    (rdDataAck && $past(rdDataAck)) |-> (rdWordAddr == TAG_W'($past(rdWordAddr) + 3'd2)));

  a_r7_no_write_pipelining: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && !reqRead && reqLine) |=> !(addrAck && !reqRead));

  a_r8_no_read_pipelining: assert property (@(posedge clk) disable iff (!rstN)
    (addrAck && reqRead) |=> !(addrAck && reqRead));

  a_r10_busy_during_beats: assert property (@(posedge clk) disable iff (!rstN)
    (rdDataAck || (wrDataAck && !(addrAck && !reqRead))) |-> busy);

  a_r11_idle_read_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdDataAck |-> (rdData == '0 && rdWordAddr == '0));
endmodule

bind splitBusResponder sbrChecker i_chk (.*);

// File: tb/test_splitBusResponder.sv
module test_splitBusResponder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqRead = 1'b0, reqLine = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0] reqByteEn = '0;
  logic [63:0] wrData = '0;
  logic addrAck, rdDataAck, wrDataAck, busy;
  logic [63:0] rdData;
  logic [2:0] rdWordAddr;

  int vectors = 0;
  int miscompares = 0;
  logic [63:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  splitBusResponder i_splitBusResponder (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .reqLine(reqLine), .reqAddr(reqAddr), .reqByteEn(reqByteEn),
    .wrData(wrData), .addrAck(addrAck), .rdData(rdData),
    .rdWordAddr(rdWordAddr), .rdDataAck(rdDataAck), .wrDataAck(wrDataAck),
    .busy(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] addrOf(input int idx, input bit oddWord);
    return 32'hA5A0_0000 | 32'(idx << 3) | 32'(oddWord << 2);
  endfunction

  task automatic idle();
    reqValid = 1'b0; reqRead = 1'b0; reqLine = 1'b0; reqByteEn = '0; wrData = '0;
  endtask

  task automatic singleWrite(input logic [31:0] addr, input logic [63:0] data, input logic [7:0] be);
    reqValid = 1'b1; reqRead = 1'b0; reqLine = 1'b0; reqAddr = addr; reqByteEn = be; wrData = data;
    #1;
    chk("R2 write ack", 64'(addrAck), 64'd1);
    chk("R3 write beat", 64'(wrDataAck), 64'd1);
    for (int i = 0; i < 8; i++)
      if (be[i]) model[addr[6:3]][i*8 +: 8] = data[i*8 +: 8];
    @(negedge clk); idle();
    #1;
    chk("R3 single beat only", 64'(wrDataAck), 64'd0);
  endtask

  task automatic singleRead(input logic [31:0] addr);
    reqValid = 1'b1; reqRead = 1'b1; reqLine = 1'b0; reqAddr = addr;
    #1;
    chk("R2 read ack", 64'(addrAck), 64'd1);
    @(negedge clk); idle();
    #1;
    chk("R5 read beat", 64'(rdDataAck), 64'd1);
    chk("R5 read data", rdData, model[addr[6:3]]);
    chk("R5 read tag", 64'(rdWordAddr), 64'(addr[4:2]));
    @(negedge clk);
    #1;
    chk("R11 idle read bus", rdData | 64'(rdWordAddr) | 64'(rdDataAck), 64'd0);
  endtask

  task automatic lineWrite(input logic [31:0] addr, input logic [63:0] d0, input logic [63:0] step);
    int base;
    base = int'(addr[6:3]) & ~3;
    reqValid = 1'b1; reqRead = 1'b0; reqLine = 1'b1; reqAddr = addr; reqByteEn = 8'h01; wrData = d0;
    #1;
    chk("R4 line write ack", 64'(addrAck), 64'd1);
    chk("R4 line beat 0", 64'(wrDataAck), 64'd1);
    model[base] = d0;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      reqValid = 1'b0; wrData = d0 + step * k;
      model[base + k] = wrData;
      #1;
      chk("R4 line beat", 64'(wrDataAck), 64'd1);
      chk("R10 busy in write", 64'(busy), 64'd1);
    end
    @(negedge clk); idle();
    #1;
    chk("R4 line write ends", 64'(wrDataAck), 64'd0);
    chk("R10 busy drops", 64'(busy), 64'd0);
  endtask

  task automatic lineRead(input logic [31:0] addr);
    int base;
    base = int'(addr[6:3]) & ~3;
    reqValid = 1'b1; reqRead = 1'b1; reqLine = 1'b1; reqAddr = addr;
    #1;
    chk("R2 line read ack", 64'(addrAck), 64'd1);
    @(negedge clk); idle();
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R6 line read beat", 64'(rdDataAck), 64'd1);
      chk("R6 line read data", rdData, model[base + k]);
      chk("R6 line read tag", 64'(rdWordAddr), 64'(2 * k));
      @(negedge clk);
    end
    #1;
    chk("R6 line read ends", 64'(rdDataAck), 64'd0);
    chk("R10 busy idle", 64'(busy), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 addrAck", 64'(addrAck), 64'd0);
    chk("R1 acks", 64'({rdDataAck, wrDataAck}), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 read bus", rdData | 64'(rdWordAddr), 64'd0);
    @(negedge clk);
    for (int i = 0; i < 16; i++) singleRead(addrOf(i, 1'b0));

    // R3/R5: full-width writes to every doubleword, read back with both word offsets
    for (int i = 0; i < 16; i++) singleWrite(addrOf(i, i[0]), 64'h1111_0000_0000_0000 * i + 64'h0F0F_1234 + i, 8'hFF);
    for (int i = 0; i < 16; i++) singleRead(addrOf(i, ~i[0]));

    // R3: exhaustive byte-enable sweep on one doubleword
    for (int be = 0; be < 256; be++) begin
      singleWrite(addrOf(5, be[0]), {8{8'(be)}} ^ 64'hA5C3_0F96_5A3C_F069, 8'(be));
      singleRead(addrOf(5, 1'b1));
    end

    // R4/R6: line writes starting mid-line, then line reads starting mid-line
    for (int l = 0; l < 4; l++) lineWrite(addrOf(4 * l + ((l + 1) % 4), l[0]), 64'hBEEF_0000_0000_0000 + 64'(l << 20), 64'h0000_0100_0000_0001);
    for (int l = 0; l < 4; l++) lineRead(addrOf(4 * l + (3 - l), 1'b1));

    // R7: write held off behind a line write
    reqValid = 1'b1; reqRead = 1'b0; reqLine = 1'b1; reqAddr = addrOf(4, 1'b0); wrData = 64'h7000;
    model[4] = 64'h7000;
    #1; chk("R7 first ack", 64'(addrAck), 64'd1);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      reqLine = 1'b0; reqAddr = addrOf(13, 1'b0); reqByteEn = 8'hFF; wrData = 64'h7000 + k;
      model[4 + k] = wrData;
      #1;
      chk("R7 second write held", 64'(addrAck), 64'd0);
      chk("R7 beat continues", 64'(wrDataAck), 64'd1);
    end
    @(negedge clk);
    wrData = 64'hD00D_F00D;
    model[13] = wrData;
    #1; chk("R7 held write taken", 64'(addrAck), 64'd1);
    @(negedge clk); idle();
    singleRead(addrOf(13, 1'b0));
    lineRead(addrOf(6, 1'b0));

    // R8: read held off behind a line read
    reqValid = 1'b1; reqRead = 1'b1; reqLine = 1'b1; reqAddr = addrOf(12, 1'b0);
    #1; chk("R8 first ack", 64'(addrAck), 64'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      reqLine = 1'b0; reqAddr = addrOf(1, 1'b1);
      #1;
      chk("R8 second read held", 64'(addrAck), 64'd0);
      chk("R8 line data", rdData, model[12 + k]);
    end
    @(negedge clk);
    #1; chk("R8 held read taken", 64'(addrAck), 64'd1);
    chk("R8 no beat in gap", 64'(rdDataAck), 64'd0);
    @(negedge clk); idle();
    #1;
    chk("R8 held read data", rdData, model[1]);
    chk("R8 held read tag", 64'(rdWordAddr), 64'd3);
    @(negedge clk);

    // R9: read accepted during a line write, beats overlap
    reqValid = 1'b1; reqRead = 1'b0; reqLine = 1'b1; reqAddr = addrOf(1, 1'b0); wrData = 64'hC0DE_0000;
    model[0] = wrData;
    #1; chk("R9 write ack", 64'(addrAck), 64'd1);
    @(negedge clk);
    reqRead = 1'b1; reqAddr = addrOf(10, 1'b0); wrData = 64'hC0DE_0001; model[1] = wrData;
    #1;
    chk("R9 read ack during write", 64'(addrAck), 64'd1);
    chk("R9 write beat 1", 64'(wrDataAck), 64'd1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (k < 2) begin wrData = 64'hC0DE_0002 + k; model[2 + k] = wrData; end
      #1;
      chk("R9 write beat overlap", 64'(wrDataAck), (k < 2) ? 64'd1 : 64'd0);
      chk("R9 read data overlap", rdData, model[8 + k]);
      chk("R9 read tag overlap", 64'(rdWordAddr), 64'(2 * k));
    end
    @(negedge clk); idle();
    #1; chk("R10 busy after overlap", 64'(busy), 64'd0);
    lineRead(addrOf(0, 1'b0));

    // R9: write accepted during a line read
    reqValid = 1'b1; reqRead = 1'b1; reqLine = 1'b1; reqAddr = addrOf(5, 1'b0);
    #1; chk("R9 read ack", 64'(addrAck), 64'd1);
    @(negedge clk);
    reqRead = 1'b0; reqLine = 1'b0; reqAddr = addrOf(14, 1'b1); reqByteEn = 8'hF0; wrData = 64'h1234_5678_9ABC_DEF0;
    model[14][63:32] = 32'h1234_5678;
    #1;
    chk("R9 write ack during read", 64'(addrAck), 64'd1);
    chk("R9 write beat during read", 64'(wrDataAck), 64'd1);
    chk("R9 read beat during write", rdData, model[4]);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); idle();
      #1; chk("R9 read continues", rdData, model[4 + k]);
    end
    @(negedge clk);
    singleRead(addrOf(14, 1'b0));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule